// File: doc/BRIEF.md
# Lane-Folded Fractional Delay Line

This block delays a serial bit stream that is carried as a parallel word of `LANES` bits per clock. Bit `i` of the word accepted as the k-th valid word is serial bit `LANES*k + i`. The block delays the stream by a fixed `DELAY` serial positions. `DELAY` does not have to be a multiple of `LANES`. A single serial shift register of `DELAY` stages would need `DELAY` clocks to pass its data through. The block instead holds the history in `LANES` short per-lane registers and uses a fixed lane rotation. The data therefore crosses in about `DELAY/LANES` valid words, and `LANES` serial bits move on every clock. The block is intended for the folded message memories of a parallel convolutional-code decoder.

The output word lines up with the word currently presented on the input. While `validIn` is high, output lane `i` carries serial bit `LANES*k + i - DELAY`, where k is the index of the word on `dataIn`. Serial positions before the start of the stream read as zero. The internal registers advance only on valid words, so stalls of any length leave the serial delay intact. Output lane `i` draws on input lane `(i - DELAY) mod LANES`. Its word depth is `ceil((DELAY - i)/LANES)`, or zero when `i >= DELAY`. For example, with `DELAY = 16` and `LANES = 3` the depths are 6, 5 and 5, which together hold exactly 16 bits.

Top module: `fold_delay_line`

## Requirements
- R1: While `validIn` is high and word k is on `dataIn`, `dataOut[i]` equals serial bit `LANES*k + i - DELAY`, where input bit `j` of word m is serial bit `LANES*m + j`. Words are counted only when `validIn` is high at a rising clock edge.
- R2: A clock edge with `validIn` low changes no stored bit. The outputs seen on later valid words are the same as if the stall had not occurred, and while the input stays stable during a stall the output stays stable.
- R3: While `rstN` is low, and after reset until `DELAY` serial bits have been accepted, every output lane whose serial position is negative reads 0.
- R4: An output lane with `i >= DELAY` (possible only when `DELAY < LANES`) follows input lane `i - DELAY` of the same word in the same cycle, with no register in between.
- R5: When `DELAY` is a multiple of `LANES`, every lane `i` equals input lane `i` of the word accepted `DELAY/LANES` valid words earlier.
- R6: With `LANES = 1` the block behaves as a plain `DELAY`-stage serial shift register that advances on valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset, clears all stored bits |
| validIn | input | 1 | High when `dataIn` carries a word to accept at the next edge |
| dataIn | input | LANES | Parallel input word; bit i is the earlier serial bit for smaller i |
| dataOut | output | LANES | Delayed word aligned with the word on `dataIn` |

## Verification
The assertions assume that `dataIn` and `validIn` hold steady around each rising edge, and they judge `dataOut` only in cycles where `validIn` is high, because an idle cycle has no word position. The stall property also assumes that the input word does not change during an idle cycle it checks. The stimulus drives every input one time unit after a rising edge and holds it for the whole cycle. It mixes long stalls with changing and unchanging data, randomly gapped valid words, and a reset in the middle of the stream. Together these cover both assumptions and the refill after reset.

// File: rtl/fold_pkg.sv
package fold_pkg;

  typedef struct packed {
    logic advance;
  } fold_strobe_t;

  // Number of stored words behind output lane idx.
  function automatic int laneDepth(int lanes, int delay, int idx);
    if (delay <= idx) return 0;
    return (delay - idx + lanes - 1) / lanes;
  endfunction

  // Input lane that feeds output lane idx.
  function automatic int laneSource(int lanes, int delay, int idx);
    int r;
    r = (idx - delay) % lanes;
    if (r < 0) r = r + lanes;
    return r;
  endfunction

endpackage

// File: rtl/fold_lane.sv
module fold_lane #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic shiftEn,
  input  logic bitIn,
  output logic bitOut
);
  logic [DEPTH-1:0] stages;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stages <= '0;
    end else if (shiftEn) begin
      stages[0] <= bitIn;
      for (int m = 1; m < DEPTH; m++) stages[m] <= stages[m-1];
    end
  end

  assign bitOut = stages[DEPTH-1];
endmodule

// File: rtl/fold_ctrl.sv
module fold_ctrl (
  input  logic                   validIn,
  output fold_pkg::fold_strobe_t strobes
);
  always_comb begin
    strobes = '0;
    strobes.advance = validIn;
  end
endmodule

// File: rtl/fold_datapath.sv
module fold_datapath #(
  parameter int LANES = 3,
  parameter int DELAY = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fold_pkg::fold_strobe_t strobes,
  input  logic [LANES-1:0]       dataIn,
  output logic [LANES-1:0]       dataOut
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int Depth  = fold_pkg::laneDepth(LANES, DELAY, gi);
    localparam int Source = fold_pkg::laneSource(LANES, DELAY, gi);
    if (Depth == 0) begin : g_pass
      assign dataOut[gi] = dataIn[Source];
    end else begin : g_store
      fold_lane #(.DEPTH(Depth)) u_lane (
        .clk    (clk),
        .rstN   (rstN),
        .shiftEn(strobes.advance),
        .bitIn  (dataIn[Source]),
        .bitOut (dataOut[gi])
      );
    end
  end
endmodule

// File: rtl/fold_delay_line.sv
module fold_delay_line #(
  parameter int LANES = 3,
  parameter int DELAY = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [LANES-1:0] dataIn,
  output logic [LANES-1:0] dataOut
);
  fold_pkg::fold_strobe_t strobes;

  fold_ctrl u_ctrl (
    .validIn(validIn),
    .strobes(strobes)
  );

  fold_datapath #(.LANES(LANES), .DELAY(DELAY)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/fold_delay_line_chk.sv
module fold_delay_line_chk #(
  parameter int LANES = 3,
  parameter int DELAY = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic [LANES-1:0] dataIn,
  input logic [LANES-1:0] dataOut
);
  // Serial history, newest bit at index 0.
  logic [DELAY-1:0] serialHist;
  int               filledBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serialHist <= '0;
      filledBits <= 0;
    end else if (validIn) begin
      for (int b = 0; b < DELAY; b++)
        serialHist[b] <= (b < LANES) ? dataIn[LANES-1-b] : serialHist[b-LANES];
      filledBits <= (filledBits + LANES >= DELAY) ? DELAY : filledBits + LANES;
    end
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_chk
    if (gi < DELAY) begin : g_hist
      p_serial_match_r1: assert property (@(posedge clk) disable iff (!rstN)
        validIn |-> dataOut[gi] == serialHist[DELAY-gi-1]);
      p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
        (validIn && (filledBits + gi < DELAY)) |-> !dataOut[gi]);
    end else begin : g_thru
      p_passthru_r4: assert property (@(posedge clk) disable iff (!rstN)
        dataOut[gi] == dataIn[gi-DELAY]);
    end
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(validIn) && $stable(dataIn)) |-> $stable(dataOut));

endmodule

bind fold_delay_line fold_delay_line_chk #(.LANES(LANES), .DELAY(DELAY)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .validIn(validIn),
  .dataIn (dataIn),
  .dataOut(dataOut)
);

// File: tb/fold_delay_line_test.sv
module fold_delay_line_harness #(
  parameter int LANES = 3,
  parameter int DELAY = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [7:0] stim,
  output int         checks,
  output int         fails
);
  logic [LANES-1:0] dataIn;
  logic [LANES-1:0] dataOut;
  logic [DELAY-1:0] hist;
  int               filled;
  bit               stalled;

  assign dataIn = stim[LANES-1:0];

  fold_delay_line #(.LANES(LANES), .DELAY(DELAY)) uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .dataIn(dataIn), .dataOut(dataOut)
  );

  function automatic logic expBit(logic [DELAY-1:0] h, logic [LANES-1:0] w, int i);
    if (i >= DELAY) return w[i-DELAY];
    return h[DELAY-i-1];
  endfunction

  function automatic string tagFor(bit inReset, int fill, int i, bit stall);
    if (inReset)                 return "R3(reset)";
    if (fill + i < DELAY)        return "R3";
    if (i >= DELAY)              return "R4";
    if (stall)                   return "R2";
    if (LANES == 1)              return "R6";
    if (DELAY % LANES == 0)      return "R5";
    return "R1";
  endfunction

  initial begin
    checks = 0; fails = 0; hist = '0; filled = 0; stalled = 0;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      hist = '0; filled = 0; stalled = 0;
      for (int i = 0; i < LANES; i++) begin
        logic e;
        e = (i >= DELAY) ? dataIn[i-DELAY] : 1'b0;
        checks++;
        if (dataOut[i] !== e) begin
          fails++;
          $display("FAIL %s L=%0d D=%0d lane %0d got %b exp %b", tagFor(1, 0, i, 0),
                   LANES, DELAY, i, dataOut[i], e);
        end
      end
    end else if (validIn) begin
      for (int i = 0; i < LANES; i++) begin
        logic e;
        e = expBit(hist, dataIn, i);
        checks++;
        if (dataOut[i] !== e) begin
          fails++;
          $display("FAIL %s L=%0d D=%0d lane %0d got %b exp %b", tagFor(0, filled, i, stalled),
                   LANES, DELAY, i, dataOut[i], e);
        end
      end
      for (int b = DELAY - 1; b >= 0; b--)
        hist[b] = (b < LANES) ? dataIn[LANES-1-b] : hist[b-LANES];
      filled  = (filled + LANES >= DELAY) ? DELAY : filled + LANES;
      stalled = 0;
    end else begin
      stalled = 1;
    end
  end
endmodule

module fold_delay_line_test;
  logic       clk = 0;
  logic       rstN = 0;
  logic       validIn = 0;
  logic [7:0] stim = '0;
  bit         timedOut = 0;

  always #2 clk = ~clk;

  int c0, f0, c1, f1, c2, f2, c3, f3, c4, f4, c5, f5;

  fold_delay_line_harness #(.LANES(3), .DELAY(16)) h0 (.clk, .rstN, .validIn, .stim, .checks(c0), .fails(f0));
  fold_delay_line_harness #(.LANES(4), .DELAY(8))  h1 (.clk, .rstN, .validIn, .stim, .checks(c1), .fails(f1));
  fold_delay_line_harness #(.LANES(4), .DELAY(2))  h2 (.clk, .rstN, .validIn, .stim, .checks(c2), .fails(f2));
  fold_delay_line_harness #(.LANES(5), .DELAY(13)) h3 (.clk, .rstN, .validIn, .stim, .checks(c3), .fails(f3));
  fold_delay_line_harness #(.LANES(1), .DELAY(7))  h4 (.clk, .rstN, .validIn, .stim, .checks(c4), .fails(f4));
  fold_delay_line_harness #(.LANES(2), .DELAY(1))  h5 (.clk, .rstN, .validIn, .stim, .checks(c5), .fails(f5));

  task automatic step(input logic v, input logic [7:0] d);
    @(posedge clk);
    #1;
    validIn = v;
    stim    = d;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    // Reset with changing input (R3 reset state)
    for (int n = 0; n < 6; n++) step(1'($urandom), 8'($urandom));
    step(1'b0, 8'hFF);
    rstN = 1;
    // R3: all-ones burst fills the line from zero
    for (int n = 0; n < 20; n++) step(1'b1, 8'hFF);
    // R2: long stall, data first changing, then steady
    for (int n = 0; n < 10; n++) step(1'b0, 8'($urandom));
    for (int n = 0; n < 10; n++) step(1'b0, 8'h5A);
    // R1/R5: walking single one
    for (int n = 0; n < 40; n++) step(1'b1, 8'(1 << (n % 8)));
    // Random stream with gaps
    for (int n = 0; n < 3000; n++) step(($urandom % 10) < 7, 8'($urandom));
    // Reset in mid-stream, then refill (R3)
    @(posedge clk); #1 rstN = 0;
    for (int n = 0; n < 3; n++) step(1'b1, 8'($urandom));
    rstN = 1;
    for (int n = 0; n < 2000; n++) step(($urandom % 4) != 0, 8'($urandom));
    step(1'b0, 8'h00);
    @(posedge clk);
    @(negedge clk);
    report();
  end

  initial begin
    #400000;
    timedOut = 1;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic report();
    int checks, fails;
    checks = c0 + c1 + c2 + c3 + c4 + c5 + (timedOut ? 1 : 0);
    fails  = f0 + f1 + f2 + f3 + f4 + f5 + (timedOut ? 1 : 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask
endmodule